// File: doc/BRIEF.md
# Serial Audio to Biphase-Mark Transmitter

This block takes stereo audio on three serial wires, a bit clock, a frame sync and a data line, and produces a single biphase-mark coded line. The serial input can be laid out left-justified, I2S or right-justified. The word length is selectable among four widths. The two words of each frame-sync period become the left and right samples. These are placed into a 32-slot subframe: a sync preamble, a 24-slot audio field, three auxiliary bits and a parity bit. The result is line-coded at two half-cells per slot.

Every input runs in the system clock domain. The serial wires are resynchronised and their edges are detected there. The output half-cell lasts a fixed number of system clocks, set by a parameter. The integrator sets that count so one output frame matches one input frame-sync period of 64 bit clocks. At the start of each output frame the encoder takes the most recent complete left/right pair. The validity, user and channel-status bits are always sent as zero.

Top module: `spdif_bmc_tx`

## Requirements
- R1: While `rst_n` is low `bmc_out` is 0, and the first subframe sent after reset carries the block-start preamble.
- R2: With format code 0 (left-justified), the sample MSB is the bit taken on the first bit-clock rising edge after a frame-sync change. N bits follow MSB first, and any later bits in that half are ignored.
- R3: With format code 1 (I2S), the sample MSB is the bit taken on the second bit-clock rising edge after a frame-sync change. The first bit and any bits after the N sample bits are ignored.
- R4: With format code 2 (right-justified), the sample is the last N bits taken before the next frame-sync change. Earlier bits in that half are ignored.
- R5: Width code 0/1/2/3 selects N = 16/18/20/24. The N-bit sample is MSB-aligned in the 24-slot audio field, and the unused low slots carry 0.
- R6: Frame sync low marks the left word and high marks the right word. Left samples go in subframes with a B or M preamble, right samples in subframes with a W preamble, and the two alternate strictly.
- R7: Each subframe has 32 slots: preamble in slots 0-3, audio LSB first in slots 4-27, validity/user/status in slots 28-30 (always 0), and in slot 31 a parity bit that makes the number of ones in slots 4-31 even.
- R8: Each half-cell lasts HALF_CYC clocks. The line toggles at the start of every slot from 4 to 31, and toggles again mid-slot only for a 1 bit.
- R9: Preambles, written as half-cell levels relative to a leading level of 1, are B = 11101000, M = 11100010 and W = 11100100. Each one begins with a toggle.
- R10: The B preamble replaces M once every 192 frames.
- R11: Format code 3 behaves exactly as left-justified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Serial bit clock, sampled on its rising edge |
| fsync_in | input | 1 | Frame sync: low = left word, high = right word |
| sdata_in | input | 1 | Serial audio data, MSB first |
| fmt_sel | input | 2 | Input layout: 0 LJ, 1 I2S, 2 RJ, 3 LJ |
| width_sel | input | 2 | Word length: 0=16, 1=18, 2=20, 3=24 bits |
| bmc_out | output | 1 | Biphase-mark coded output line |

## Verification
The bench sweeps all four format codes against all four width codes with two sample patterns each. The first pattern is a dense mixed value with different left and right words. The second is a lone LSB on the left against a lone MSB on the right, which exposes any off-by-one in alignment or slot order. Each half-word is padded with a fixed non-zero filler around the sample bits. A deserializer that samples one bit too early, one bit too late or at the wrong end of the half therefore decodes a visibly different word. The output line is decoded independently from its run lengths, which checks preamble shapes, parity, cell-boundary toggles, subframe alternation and the spacing of block starts.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

   typedef enum logic [1:0] {
      FMT_LJ     = 2'd0,
      FMT_I2S    = 2'd1,
      FMT_RJ     = 2'd2,
      FMT_LJ_ALT = 2'd3
   } in_fmt_e;

   typedef enum logic [1:0] {
      PRE_B = 2'd0,
      PRE_M = 2'd1,
      PRE_W = 2'd2
   } pre_e;

   localparam int SLOTS_PER_SUB = 32;
   localparam int FIELD_W       = 24;
   localparam int FIELD_LO      = 4;
   localparam int FIELD_HI      = 27;
   localparam int PARITY_SLOT   = 31;

   // Word length for a width code; the four choices sit at aud_w-8 .. aud_w.
   function automatic int width_of(input logic [1:0] sel, input int aud_w);
      case (sel)
         2'd0:    return aud_w - 8;
         2'd1:    return aud_w - 6;
         2'd2:    return aud_w - 4;
         default: return aud_w;
      endcase
   endfunction

   // Toggle flag for half-cell idx (0..7) of a preamble, msb = first half.
   function automatic logic pre_tog(input pre_e p, input logic [2:0] idx);
      logic [7:0] pat;
      case (p)
         PRE_B:   pat = 8'b1001_1100;
         PRE_M:   pat = 8'b1001_0011;
         default: pat = 8'b1001_0110;
      endcase
      return pat[3'd7 - idx];
   endfunction

endpackage

// File: rtl/spdif_in_deser.sv
module spdif_in_deser
   import spdif_tx_pkg::*;
#(
   parameter int AUD_W       = 24,
   parameter int MAX_HALF    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_in,
   input  logic             fsync_in,
   input  logic             sdata_in,
   input  logic [1:0]       fmt_sel,
   input  logic [1:0]       width_sel,
   output logic             word_vld,
   output logic             word_right,
   output logic [AUD_W-1:0] word_out
);

   localparam int CW = $clog2(MAX_HALF + 1);

   logic [2:0] raw_in;
   logic [2:0] syn_in;

   assign raw_in = {bclk_in, fsync_in, sdata_in};

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign syn_in = raw_in;
      end else begin : g_sync
         logic [2:0] stage_q [SYNC_STAGES];
         for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n)      stage_q[s] <= '0;
               else if (s == 0) stage_q[s] <= raw_in;
               else             stage_q[s] <= stage_q[s-1];
            end
         end
         assign syn_in = stage_q[SYNC_STAGES-1];
      end
   endgenerate

   logic                s_bclk, s_fs, s_dat;
   logic                bclk_d;
   logic                fs_prev;
   logic                bit_rise;
   logic [MAX_HALF-1:0] shreg;
   logic [CW-1:0]       bit_cnt;
   logic [AUD_W-1:0]    pick_word;

   assign {s_bclk, s_fs, s_dat} = syn_in;
   assign bit_rise = s_bclk & ~bclk_d;

   // Extract the finished half-word from the shift history.
   always_comb begin
      int                n;
      int                sa;
      logic [MAX_HALF-1:0] tmp;
      logic [MAX_HALF-1:0] msk;
      logic [MAX_HALF-1:0] aligned;
      n = width_of(width_sel, AUD_W);
      case (in_fmt_e'(fmt_sel))
         FMT_I2S: sa = int'(bit_cnt) - n - 1;
         FMT_RJ:  sa = 0;
         default: sa = int'(bit_cnt) - n;
      endcase
      if (sa < 0) sa = 0;
      tmp       = shreg >> sa;
      msk       = (MAX_HALF'(1) << n) - MAX_HALF'(1);
      aligned   = (tmp & msk) << (AUD_W - n);
      pick_word = aligned[AUD_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bclk_d     <= 1'b0;
         fs_prev    <= 1'b0;
         shreg      <= '0;
         bit_cnt    <= '0;
         word_vld   <= 1'b0;
         word_right <= 1'b0;
         word_out   <= '0;
      end else begin
         bclk_d   <= s_bclk;
         word_vld <= 1'b0;
         if (bit_rise) begin
            if (s_fs != fs_prev) begin
               word_vld   <= 1'b1;
               word_right <= fs_prev;
               word_out   <= pick_word;
               bit_cnt    <= CW'(1);
            end else if (bit_cnt != CW'(MAX_HALF)) begin
               bit_cnt <= bit_cnt + CW'(1);
            end
            shreg   <= {shreg[MAX_HALF-2:0], s_dat};
            fs_prev <= s_fs;
         end
      end
   end

endmodule

// File: rtl/spdif_pair_hold.sv
module spdif_pair_hold #(
   parameter int AUD_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             word_vld,
   input  logic             word_right,
   input  logic [AUD_W-1:0] word_in,
   output logic [AUD_W-1:0] pair_l,
   output logic [AUD_W-1:0] pair_r
);

   logic [AUD_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         pair_l <= '0;
         pair_r <= '0;
      end else if (word_vld) begin
         if (!word_right) begin
            left_q <= word_in;
         end else begin
            pair_l <= left_q;
            pair_r <= word_in;
         end
      end
   end

endmodule

// File: rtl/spdif_sub_enc.sv
module spdif_sub_enc
   import spdif_tx_pkg::*;
#(
   parameter int AUD_W        = 24,
   parameter int HALF_CYC     = 4,
   parameter int BLOCK_FRAMES = 192
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AUD_W-1:0] pair_l,
   input  logic [AUD_W-1:0] pair_r,
   output logic             bmc_out,
   output logic             half_tick,
   output logic [4:0]       slot_idx,
   output logic             half_idx
);

   localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam int FW = (BLOCK_FRAMES > 1) ? $clog2(BLOCK_FRAMES) : 1;

   logic [DW-1:0]      div_q;
   logic [4:0]         slot_q;
   logic               half_q;
   logic               sub_q;
   logic [FW-1:0]      frm_q;
   logic               lvl_q;
   logic               par_q;
   logic [AUD_W-1:0]   cur_l, cur_r;
   logic [FIELD_W-1:0] field;
   logic               bit_now;
   logic               tog;
   pre_e               ptype;

   assign half_tick = (div_q == DW'(HALF_CYC - 1));
   assign slot_idx  = slot_q;
   assign half_idx  = half_q;
   assign bmc_out   = lvl_q;

   assign field = FIELD_W'(sub_q ? cur_r : cur_l) << (FIELD_W - AUD_W);

   always_comb begin
      logic [4:0] ai;
      ai      = slot_q - 5'(FIELD_LO);
      bit_now = 1'b0;
      if (slot_q >= 5'(FIELD_LO) && slot_q <= 5'(FIELD_HI))
         bit_now = field[ai];
      else if (slot_q == 5'(PARITY_SLOT))
         bit_now = par_q;
   end

   always_comb begin
      if (sub_q)             ptype = PRE_W;
      else if (frm_q == '0)  ptype = PRE_B;
      else                   ptype = PRE_M;
      if (slot_q < 5'(FIELD_LO))
         tog = pre_tog(ptype, {slot_q[1:0], half_q});
      else
         tog = half_q ? bit_now : 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= '0;
         slot_q <= '0;
         half_q <= 1'b0;
         sub_q  <= 1'b0;
         frm_q  <= '0;
         lvl_q  <= 1'b0;
         par_q  <= 1'b0;
         cur_l  <= '0;
         cur_r  <= '0;
      end else begin
         div_q <= half_tick ? '0 : div_q + DW'(1);
         if (half_tick) begin
            lvl_q  <= lvl_q ^ tog;
            half_q <= ~half_q;
            if (slot_q == 5'd0)
               par_q <= 1'b0;
            else if (half_q && slot_q >= 5'(FIELD_LO) && slot_q < 5'(PARITY_SLOT))
               par_q <= par_q ^ bit_now;
            if (half_q) begin
               slot_q <= slot_q + 5'd1;
               if (slot_q == 5'(SLOTS_PER_SUB - 1)) begin
                  sub_q <= ~sub_q;
                  if (sub_q) begin
                     frm_q <= (frm_q == FW'(BLOCK_FRAMES - 1)) ? '0 : frm_q + FW'(1);
                     cur_l <= pair_l;
                     cur_r <= pair_r;
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/spdif_bmc_tx.sv
module spdif_bmc_tx #(
   parameter int AUD_W        = 24,
   parameter int MAX_HALF     = 32,
   parameter int HALF_CYC     = 4,
   parameter int BLOCK_FRAMES = 192,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bclk_in,
   input  logic       fsync_in,
   input  logic       sdata_in,
   input  logic [1:0] fmt_sel,
   input  logic [1:0] width_sel,
   output logic       bmc_out
);

   if (AUD_W < 9 || AUD_W > 24) begin : g_bad_aud
      $error("AUD_W must lie in 9..24");
   end
   if (MAX_HALF < AUD_W + 1) begin : g_bad_half
      $error("MAX_HALF must exceed AUD_W");
   end
   if (HALF_CYC < 1) begin : g_bad_cyc
      $error("HALF_CYC must be at least 1");
   end
   if (BLOCK_FRAMES < 2) begin : g_bad_blk
      $error("BLOCK_FRAMES must be at least 2");
   end

   logic             word_vld;
   logic             word_right;
   logic [AUD_W-1:0] word_val;
   logic [AUD_W-1:0] pair_l, pair_r;
   logic             enc_tick;
   logic [4:0]       enc_slot;
   logic             enc_half;

   spdif_in_deser #(
      .AUD_W(AUD_W), .MAX_HALF(MAX_HALF), .SYNC_STAGES(SYNC_STAGES)
   ) i_deser (
      .clk(clk), .rst_n(rst_n),
      .bclk_in(bclk_in), .fsync_in(fsync_in), .sdata_in(sdata_in),
      .fmt_sel(fmt_sel), .width_sel(width_sel),
      .word_vld(word_vld), .word_right(word_right), .word_out(word_val)
   );

   spdif_pair_hold #(.AUD_W(AUD_W)) i_hold (
      .clk(clk), .rst_n(rst_n),
      .word_vld(word_vld), .word_right(word_right), .word_in(word_val),
      .pair_l(pair_l), .pair_r(pair_r)
   );

   spdif_sub_enc #(
      .AUD_W(AUD_W), .HALF_CYC(HALF_CYC), .BLOCK_FRAMES(BLOCK_FRAMES)
   ) i_enc (
      .clk(clk), .rst_n(rst_n),
      .pair_l(pair_l), .pair_r(pair_r),
      .bmc_out(bmc_out), .half_tick(enc_tick),
      .slot_idx(enc_slot), .half_idx(enc_half)
   );

endmodule

// File: rtl/spdif_bmc_tx_chk.sv
module spdif_bmc_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bmc_out,
   input logic       tick,
   input logic [4:0] slot,
   input logic       half
);

   logic lvl_at_field;

   always_ff @(posedge clk) begin
      if (!rst_n)                             lvl_at_field <= 1'b0;
      else if (tick && slot == 5'd4 && !half) lvl_at_field <= bmc_out;
   end

   // R8
   line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bmc_out) |-> $past(tick));

   // R8
   cell_edge_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && slot >= 5'd4 && !half) |=> (bmc_out != $past(bmc_out)));

   // R9
   preamble_lead_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && slot == 5'd0 && !half) |=> (bmc_out != $past(bmc_out)));

   // R7
   aux_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && slot >= 5'd28 && slot <= 5'd30 && half) |=> $stable(bmc_out));

   // R7
   even_parity_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && slot == 5'd31 && half) |=> (bmc_out == lvl_at_field));

endmodule

bind spdif_bmc_tx spdif_bmc_tx_chk i_chk (
   .clk(clk), .rst_n(rst_n), .bmc_out(bmc_out),
   .tick(enc_tick), .slot(enc_slot), .half(enc_half)
);

// File: tb/test_spdif_bmc_tx.sv
`timescale 1ns/1ps
module test_spdif_bmc_tx;

   localparam int HC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bclk = 1'b0, fsync = 1'b0, sdata = 1'b0;
   logic [1:0] fmt_sel = 2'd0, width_sel = 2'd3;
   logic       bmc_out;

   always #5 clk = ~clk;

   spdif_bmc_tx #(.HALF_CYC(HC)) i_spdif_bmc_tx (
      .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .fsync_in(fsync),
      .sdata_in(sdata), .fmt_sel(fmt_sel), .width_sel(width_sel),
      .bmc_out(bmc_out)
   );

   int checks = 0, failures = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- independent line decoder ----------------
   logic        hv [64];
   int          pos = 0, runlen = 0;
   logic        lastlvl = 0;
   bit          synced = 0, ever_valid = 0;
   int          n_sub = 0, bad_par = 0, bad_bmc = 0, bad_aux = 0, bad_seq = 0;
   int          bad_run = 0, bad_sync = 0;
   int          prev_type = -1, first_type = -1, frames_since_b = -1, blk_checks = 0;
   logic [23:0] last_l = '0, last_r = '0;

   task automatic decode_sub();
      logic [7:0]  rel;
      logic [23:0] aud;
      logic        v, u, c, p;
      int          t;
      for (int i = 0; i < 8; i++) rel[7-i] = hv[i] ^ hv[0] ^ 1'b1;
      if (rel == 8'b11101000)      t = 0;
      else if (rel == 8'b11100010) t = 1;
      else if (rel == 8'b11100100) t = 2;
      else                         t = 3;
      if (t == 3) begin
         if (ever_valid) bad_sync++;
         synced = 0;
         return;
      end
      ever_valid = 1;
      n_sub++;
      for (int k = 0; k < 24; k++) aud[k] = hv[2*(4+k)] ^ hv[2*(4+k)+1];
      v = hv[56] ^ hv[57]; u = hv[58] ^ hv[59]; c = hv[60] ^ hv[61]; p = hv[62] ^ hv[63];
      if ((^aud ^ v ^ u ^ c ^ p) != 1'b0) bad_par++;        // R7
      if (v | u | c) bad_aux++;                              // R7
      for (int s = 4; s < 32; s++) if (hv[2*s] == hv[2*s-1]) bad_bmc++;   // R8
      if (first_type < 0) first_type = t;
      if (prev_type >= 0 && ((t == 2) == (prev_type == 2))) bad_seq++;  // R6
      prev_type = t;
      if (t == 2) last_r = aud;
      else begin
         last_l = aud;
         if (t == 0) begin
            if (frames_since_b >= 0) begin
               chk(frames_since_b == 192, "R10 block start spacing", frames_since_b, 192);
               blk_checks++;
            end
            frames_since_b = 1;
         end else if (frames_since_b >= 0) frames_since_b++;
      end
   endtask

   task automatic push_run(input logic lvl, input int len);
      int halves;
      if (synced && (len % HC) != 0) bad_run++;               // R8
      halves = len / HC;
      if (!synced) begin
         if (halves != 3) return;
         synced = 1;
         pos = 0;
      end
      for (int k = 0; k < halves; k++) begin
         hv[pos] = lvl;
         pos++;
         if (pos == 64) begin
            pos = 0;
            decode_sub();
            if (!synced) return;
         end
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         runlen  = 0;
         lastlvl = 1'b0;
      end else if (bmc_out == lastlvl) runlen++;
      else begin
         push_run(lastlvl, runlen);
         lastlvl = bmc_out;
         runlen  = 1;
      end
   end

   // ---------------- serial driver ----------------
   int cur_n = 24;
   logic [1:0] cur_fmt = 2'd0;
   localparam logic [31:0] FILL = 32'hD1B4_6E2F;

   function automatic logic [31:0] build(input logic [23:0] w);
      logic [31:0] vec;
      vec = FILL;
      for (int i = 0; i < cur_n; i++) begin
         case (cur_fmt)
            2'd1:    vec[30-i]        = w[cur_n-1-i];
            2'd2:    vec[cur_n-1-i]   = w[cur_n-1-i];
            default: vec[31-i]        = w[cur_n-1-i];
         endcase
      end
      return vec;
   endfunction

   task automatic send_frame(input logic [23:0] wl, input logic [23:0] wr);
      for (int h = 0; h < 2; h++) begin
         logic [31:0] vec;
         vec = build(h == 0 ? wl : wr);
         for (int b = 0; b < 32; b++) begin
            @(negedge clk);
            bclk = 1'b0; fsync = h[0]; sdata = vec[31-b];
            @(negedge clk); @(negedge clk);
            bclk = 1'b1;
            @(negedge clk);
         end
      end
   endtask

   function automatic string fmt_tag(input logic [1:0] f);
      case (f)
         2'd0: return "R2 left-justified";
         2'd1: return "R3 i2s";
         2'd2: return "R4 right-justified";
         default: return "R11 code3-as-LJ";
      endcase
   endfunction

   task automatic finish_up();
      chk(n_sub > 300, "R7 subframes decoded", n_sub, 300);
      chk(bad_par == 0, "R7 even parity", bad_par, 0);
      chk(bad_aux == 0, "R7 aux bits zero", bad_aux, 0);
      chk(bad_bmc == 0, "R8 cell boundary toggles", bad_bmc, 0);
      chk(bad_run == 0, "R8 half-cell length", bad_run, 0);
      chk(bad_sync == 0, "R9 preamble shapes", bad_sync, 0);
      chk(bad_seq == 0, "R6 left/right alternation", bad_seq, 0);
      chk(first_type == 0, "R1 first preamble is B", first_type, 0);
      chk(blk_checks > 0, "R10 block start seen twice", blk_checks, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk(bmc_out == 1'b0, "R1 reset output low", bmc_out, 0);
      rst_n = 1'b1;
      for (int f = 0; f < 4; f++) begin
         for (int w = 0; w < 4; w++) begin
            for (int p = 0; p < 2; p++) begin
               logic [23:0] wl, wr, el, er, msk;
               cur_fmt = f[1:0]; cur_n = 16 + 2*w + ((w == 3) ? 2 : 0);
               fmt_sel = cur_fmt; width_sel = w[1:0];
               msk = (24'd1 << cur_n) - 24'd1;
               if (p == 0) begin
                  wl = 24'hC35A96 & msk;
                  wr = 24'h2B71E4 & msk;
               end else begin
                  wl = 24'd1;
                  wr = 24'd1 << (cur_n - 1);
               end
               el = wl << (24 - cur_n);
               er = wr << (24 - cur_n);
               repeat (5) send_frame(wl, wr);
               chk(last_l == el, {fmt_tag(cur_fmt), " R5 R6 left word"}, last_l, el);
               chk(last_r == er, {fmt_tag(cur_fmt), " R5 R6 right word"}, last_r, er);
            end
         end
      end
      repeat (70) send_frame(24'h0, 24'h0);
      finish_up();
      done = 1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog expired", 0, 1);
         finish_up();
         $finish;
      end
   end

endmodule